// File: doc/BRIEF.md
# Multi-mode multiply-accumulate unit

This block is a fixed-point multiply-accumulate unit. Its multiplier array can be partitioned on every cycle by a mode input as three signed 9x9 products, two signed 18x18 products, or one signed 27x27 product. In the multi-product modes the products are sign-extended to the accumulator width and summed. The product sum then goes to a 64-bit adder/subtractor. That adder also takes a cascade input from an upstream unit, and its result drives a cascade output to a downstream unit. Chained units therefore form a sum-of-products without extra adders.

Two feedback registers let one unit carry two independent accumulation channels. A channel-select input picks the register that is read and written on each cycle. An output stage adds one half at a parameterized bit position and keeps a window of the biased value, which gives round-half-up to a narrower result one cycle after the accumulator output.

Top module: `mmac_unit`

## Requirements
- R1: While rst_ni is low and after reset is released, acc_o, casc_o, rnd_o and both channel registers are zero.
- R2: With mode_i = 2'b00 the product sum is the sum of the three signed products a_i[9k+8:9k] * b_i[9k+8:9k] for k = 0, 1, 2.
- R3: With mode_i = 2'b01 the product sum is the sum of the two signed products a_i[18k+17:18k] * b_i[18k+17:18k] for k = 0, 1.
- R4: With mode_i = 2'b10 or 2'b11 the product sum is the single signed product a_i[26:0] * b_i[26:0].
- R5: With en_i high, clr_i low and accum_i low, the selected channel loads casc_i plus (or minus) the product sum, and acc_o shows that value after the next rising edge.
- R6: With en_i high, clr_i low and accum_i high, the selected channel becomes its old value plus casc_i plus (or minus) the product sum, and acc_o shows it after the next edge.
- R7: sub_i = 1 subtracts the product sum and sub_i = 0 adds it. The cascade input is always added.
- R8: ch_i selects which of the two channel registers is read and updated. The other channel keeps its value.
- R9: clr_i high zeroes the selected channel and acc_o at the next edge, whatever en_i is.
- R10: With en_i and clr_i both low, acc_o and both channels hold their values.
- R11: casc_o always equals acc_o.
- R12: On every edge rnd_o takes bits [RND_POS+OUT_W-1:RND_POS] of acc_o + 2^(RND_POS-1), as acc_o stood before that edge (defaults 16 and 48). Fractions of one half or more round up, smaller fractions round down, and exact halves go toward plus infinity.
- R13: All adds wrap modulo 2^64 and no saturation is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Update the selected channel this cycle |
| mode_i | input | 2 | Multiplier partitioning: 00 three 9x9, 01 two 18x18, 1x one 27x27 |
| a_i | input | 36 | Packed multiplier operands A |
| b_i | input | 36 | Packed multiplier operands B |
| sub_i | input | 1 | Subtract the product sum instead of adding it |
| accum_i | input | 1 | Add into the channel's old value instead of loading |
| clr_i | input | 1 | Zero the selected channel |
| ch_i | input | 1 | Channel select |
| casc_i | input | 64 | Cascade input from the upstream unit |
| acc_o | output | 64 | Last value written to a channel |
| casc_o | output | 64 | Cascade output to the downstream unit |
| rnd_o | output | 48 | Rounded and truncated result |

## Verification
The properties assume that every input is a known value from the clock edge after reset onward. They also assume that the rounding parameters keep the kept window inside the accumulator, with RND_POS at least one. The bench drives every input with a defined value on each falling edge, including the cycles with en_i low. It keeps the default parameters. Random operands, modes and controls therefore never leave the space that the properties describe.

// File: rtl/mmac_pkg.sv
package mmac_pkg;
  localparam logic [1:0] MODE_3X9  = 2'd0;
  localparam logic [1:0] MODE_2X18 = 2'd1;
  localparam logic [1:0] MODE_1X27 = 2'd2;
endpackage

// File: rtl/mmac_mult_array.sv
module mmac_mult_array
  import mmac_pkg::*;
#(
  parameter int BASE_W = 9,
  parameter int ACC_W  = 64,
  localparam int OP_W  = 4 * BASE_W
) (
  input  logic [1:0]       mode_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [ACC_W-1:0] sum_o
);
  localparam int W1 = BASE_W;
  localparam int W2 = 2 * BASE_W;
  localparam int W3 = 3 * BASE_W;

  logic [ACC_W-1:0] e1 [3];
  logic [ACC_W-1:0] e2 [2];
  logic [ACC_W-1:0] e3;

  for (genvar k = 0; k < 3; k++) begin : g_l1
    logic signed [2*W1-1:0] p;
    assign p     = $signed(a_i[k*W1 +: W1]) * $signed(b_i[k*W1 +: W1]);
    assign e1[k] = {{(ACC_W-2*W1){p[2*W1-1]}}, p};
  end

  for (genvar k = 0; k < 2; k++) begin : g_l2
    logic signed [2*W2-1:0] p;
    assign p     = $signed(a_i[k*W2 +: W2]) * $signed(b_i[k*W2 +: W2]);
    assign e2[k] = {{(ACC_W-2*W2){p[2*W2-1]}}, p};
  end

  logic signed [2*W3-1:0] p3;
  assign p3 = $signed(a_i[W3-1:0]) * $signed(b_i[W3-1:0]);
  assign e3 = {{(ACC_W-2*W3){p3[2*W3-1]}}, p3};

  always_comb begin
    case (mode_i)
      MODE_3X9:  sum_o = e1[0] + e1[1] + e1[2];
      MODE_2X18: sum_o = e2[0] + e2[1];
      default:   sum_o = e3;
    endcase
  end
endmodule

// File: rtl/mmac_acc_bank.sv
module mmac_acc_bank #(
  parameter int ACC_W = 64,
  parameter int CH    = 2,
  localparam int CH_W = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             accum_i,
  input  logic             sub_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic [ACC_W-1:0] sum_i,
  input  logic [ACC_W-1:0] casc_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q [CH];
  logic [ACC_W-1:0] fb, term, nxt;

  always_comb begin
    fb   = accum_i ? acc_q[ch_i] : '0;
    term = sub_i ? (~sum_i + ACC_W'(1)) : sum_i;
    nxt  = fb + casc_i + term;  // wraps, no saturation
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CH; i++) acc_q[i] <= '0;
      acc_o <= '0;
    end else if (clr_i) begin
      acc_q[ch_i] <= '0;
      acc_o       <= '0;
    end else if (en_i) begin
      acc_q[ch_i] <= nxt;
      acc_o       <= nxt;
    end
  end
endmodule

// File: rtl/mmac_round.sv
module mmac_round #(
  parameter int ACC_W   = 64,
  parameter int RND_POS = 16,
  parameter int OUT_W   = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] val_i,
  output logic [OUT_W-1:0] rnd_o
);
  localparam int               HS   = (RND_POS > 0) ? RND_POS - 1 : 0;
  localparam logic [ACC_W-1:0] HALF = (RND_POS > 0) ? (ACC_W'(1) << HS) : '0;

  logic [ACC_W-1:0] biased;
  assign biased = val_i + HALF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rnd_o <= '0;
    else         rnd_o <= OUT_W'(biased >> RND_POS);
  end
endmodule

// File: rtl/mmac_unit.sv
module mmac_unit #(
  parameter int BASE_W  = 9,
  parameter int ACC_W   = 64,
  parameter int RND_POS = 16,
  parameter int OUT_W   = 48,
  localparam int OP_W   = 4 * BASE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic             sub_i,
  input  logic             accum_i,
  input  logic             clr_i,
  input  logic             ch_i,
  input  logic [ACC_W-1:0] casc_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] casc_o,
  output logic [OUT_W-1:0] rnd_o
);
  logic [ACC_W-1:0] prod_sum;

  mmac_mult_array #(.BASE_W(BASE_W), .ACC_W(ACC_W)) u_mult (
    .mode_i (mode_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_o  (prod_sum)
  );

  mmac_acc_bank #(.ACC_W(ACC_W), .CH(2)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .clr_i   (clr_i),
    .accum_i (accum_i),
    .sub_i   (sub_i),
    .ch_i    (ch_i),
    .sum_i   (prod_sum),
    .casc_i  (casc_i),
    .acc_o   (acc_o)
  );

  assign casc_o = acc_o;

  mmac_round #(.ACC_W(ACC_W), .RND_POS(RND_POS), .OUT_W(OUT_W)) u_rnd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .val_i  (acc_o),
    .rnd_o  (rnd_o)
  );
endmodule

// File: rtl/mmac_unit_chk.sv
module mmac_unit_chk
  import mmac_pkg::*;
#(
  parameter int BASE_W  = 9,
  parameter int ACC_W   = 64,
  parameter int RND_POS = 16,
  parameter int OUT_W   = 48,
  localparam int W3     = 3 * BASE_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             clr_i,
  input logic             accum_i,
  input logic             sub_i,
  input logic [1:0]       mode_i,
  input logic [W3-1:0]    a27_i,
  input logic [W3-1:0]    b27_i,
  input logic [ACC_W-1:0] casc_i,
  input logic [ACC_W-1:0] acc_o,
  input logic [OUT_W-1:0] rnd_o
);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (RND_POS - 1);

  logic signed [2*W3-1:0] p27;
  logic [ACC_W-1:0]       p27_x, rnd_ref;
  assign p27     = $signed(a27_i) * $signed(b27_i);
  assign p27_x   = {{(ACC_W-2*W3){p27[2*W3-1]}}, p27};
  assign rnd_ref = (acc_o + HALF) >> RND_POS;

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !clr_i |=> $stable(acc_o));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_o == '0);

  assert_round_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> rnd_o == $past(rnd_ref[OUT_W-1:0]));

  assert_load27_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && !accum_i && !sub_i && mode_i == MODE_1X27
    |=> acc_o == $past(casc_i) + $past(p27_x));

  assert_sub27_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && !accum_i && sub_i && mode_i == MODE_1X27
    |=> acc_o == $past(casc_i) - $past(p27_x));
endmodule

bind mmac_unit mmac_unit_chk #(
  .BASE_W(BASE_W), .ACC_W(ACC_W), .RND_POS(RND_POS), .OUT_W(OUT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .clr_i   (clr_i),
  .accum_i (accum_i),
  .sub_i   (sub_i),
  .mode_i  (mode_i),
  .a27_i   (a_i[3*BASE_W-1:0]),
  .b27_i   (b_i[3*BASE_W-1:0]),
  .casc_i  (casc_i),
  .acc_o   (acc_o),
  .rnd_o   (rnd_o)
);

// File: tb/tb_mmac_unit.sv
`timescale 1ns/1ps
module tb_mmac_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 0, sub_i = 0, accum_i = 0, clr_i = 0, ch_i = 0;
  logic [1:0]  mode_i = '0;
  logic [35:0] a_i = '0, b_i = '0;
  logic [63:0] casc_i = '0;
  logic [63:0] acc_o, casc_o;
  logic [47:0] rnd_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [63:0] m_ch [2];
  logic [63:0] m_acc;
  logic [47:0] m_rnd;

  always #2 clk_i = ~clk_i;

  mmac_unit dut (.*);

  function automatic logic [63:0] psum(logic [1:0] m, logic [35:0] a, logic [35:0] b);
    longint s = 0;
    if (m == 2'd0)
      for (int k = 0; k < 3; k++)
        s += longint'($signed(a[k*9 +: 9])) * longint'($signed(b[k*9 +: 9]));
    else if (m == 2'd1)
      for (int k = 0; k < 2; k++)
        s += longint'($signed(a[k*18 +: 18])) * longint'($signed(b[k*18 +: 18]));
    else
      s = longint'($signed(a[26:0])) * longint'($signed(b[26:0]));
    return 64'(s);
  endfunction

  function automatic logic [47:0] rnd(logic [63:0] v);
    logic [63:0] t = v + 64'h8000;
    return t[63:16];
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic en, logic [1:0] m, logic [35:0] a, logic [35:0] b,
                      logic sb, logic ac, logic cl, logic ch, logic [63:0] cs);
    logic [63:0] t;
    en_i = en; mode_i = m; a_i = a; b_i = b; sub_i = sb;
    accum_i = ac; clr_i = cl; ch_i = ch; casc_i = cs;
    m_rnd = rnd(m_acc);
    if (cl) begin
      m_ch[ch] = '0; m_acc = '0;
    end else if (en) begin
      t = (ac ? m_ch[ch] : 64'd0) + cs + (sb ? -psum(m, a, b) : psum(m, a, b));
      m_ch[ch] = t; m_acc = t;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk(tag, acc_o, m_acc);
    chk("R11", casc_o, acc_o);
    chk("R12", 64'(rnd_o), 64'(m_rnd));
  endtask

  // one-cycle idle step to expose rounding of the present value
  task automatic idle();
    step("R10", 0, 2'd3, '1, '1, 1, 1, 0, 0, '1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    m_ch[0] = '0; m_ch[1] = '0; m_acc = '0; m_rnd = '0;
    @(negedge clk_i);
    chk("R1", acc_o, 64'd0);
    chk("R1", 64'(rnd_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", casc_o, 64'd0);

    // R2: 9-bit lanes (-1*3) + (5*-7) + (100*2) = 162
    step("R2", 1, 2'd0, {9'd0, 9'd100, 9'd5, 9'h1FF}, {9'd0, 9'd2, 9'h1F9, 9'd3}, 0, 0, 0, 0, 64'd0);
    chk("R2", acc_o, 64'd162);
    // R3: 18-bit lanes
    step("R3", 1, 2'd1, {18'h3FFFF, 18'd1000}, {18'd7, 18'h20000}, 0, 0, 0, 0, 64'd10);
    // R4: 27-bit product, both encodings
    step("R4", 1, 2'd2, 36'h0_03FF_FFFF, 36'h0_0400_0001, 0, 0, 0, 0, 64'd0);
    step("R4", 1, 2'd3, 36'hF_FC00_0000, 36'h0_0400_0000, 0, 0, 0, 1, 64'd5);
    // R7: subtraction
    step("R7", 1, 2'd2, 36'd300, 36'd4, 1, 0, 0, 0, 64'd1000);
    chk("R7", acc_o, 64'd1000 - 64'd1200);
    // R5/R6/R8: two channels
    step("R5", 1, 2'd2, 36'd0, 36'd0, 0, 0, 0, 1, 64'd1000);
    step("R5", 1, 2'd2, 36'd0, 36'd0, 0, 0, 0, 0, 64'd5);
    step("R6", 1, 2'd0, 36'd3, 36'd3, 0, 1, 0, 1, 64'd0);
    chk("R6", acc_o, 64'd1009);
    step("R8", 1, 2'd2, 36'd0, 36'd0, 0, 1, 0, 0, 64'd0);
    chk("R8", acc_o, 64'd5);
    // R9: clear beats enable, other channel untouched
    step("R9", 1, 2'd2, 36'd7, 36'd7, 0, 1, 1, 1, 64'd77);
    step("R8", 1, 2'd2, 36'd0, 36'd0, 0, 1, 0, 1, 64'd0);
    chk("R9", acc_o, 64'd0);
    step("R8", 1, 2'd2, 36'd0, 36'd0, 0, 1, 0, 0, 64'd0);
    chk("R8", acc_o, 64'd5);
    // R10: disabled cycles
    idle(); idle();
    // R12: fractions .6, .1, exact +.5 and -.5
    step("R5", 1, 2'd2, 36'd0, 36'd0, 0, 0, 0, 0, 64'h1_999A);
    idle(); chk("R12", 64'(rnd_o), 64'd2);
    step("R5", 1, 2'd2, 36'd0, 36'd0, 0, 0, 0, 0, 64'h1_1999);
    idle(); chk("R12", 64'(rnd_o), 64'd1);
    step("R5", 1, 2'd2, 36'd0, 36'd0, 0, 0, 0, 0, 64'h8000);
    idle(); chk("R12", 64'(rnd_o), 64'd1);
    step("R5", 1, 2'd2, 36'd0, 36'd0, 0, 0, 0, 0, -64'sh8000);
    idle(); chk("R12", 64'(rnd_o), 64'd0);
    // R13: wrap
    step("R13", 1, 2'd2, 36'd1, 36'd1, 0, 0, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF);
    chk("R13", acc_o, 64'h8000_0000_0000_0000);
    step("R13", 1, 2'd2, 36'd1, 36'd1, 1, 1, 0, 0, 64'd0);
    chk("R13", acc_o, 64'h7FFF_FFFF_FFFF_FFFF);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  m  = 2'($urandom);
      logic [35:0] a  = {4'($urandom), 32'($urandom)};
      logic [35:0] b  = {4'($urandom), 32'($urandom)};
      logic        en = ($urandom % 8) != 0;
      logic        cl = ($urandom % 16) == 0;
      logic        ac = $urandom;
      logic        sb = $urandom;
      logic        ch = $urandom;
      logic [63:0] cs = ($urandom % 2) ? {32'($urandom), 32'($urandom)} : 64'($urandom % 1024);
      string tag = cl ? "R9" : !en ? "R10" : sb ? "R7" : ac ? "R6" : "R5";
      step(tag, en, m, a, b, sb, ac, cl, ch, cs);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule